// File: doc/BRIEF.md
# Serial Max-Log-MAP Soft-In Soft-Out Component Decoder

This block decodes one block of a rate-1/2, 8-state recursive systematic convolutional component code, as used inside an iterative parallel-concatenated decoder. Before a run, the surrounding logic writes a systematic LLR, a parity LLR and an a-priori LLR for every trellis step through a load port into on-block input buffers. A start pulse with a block length then launches the decode.

A single add-compare-select recursion unit first runs the forward recursion over the block. It stores the forward metrics of every step in a metric memory as one row of eight values. The same unit then runs the backward recursion. In each backward step a soft-output stage combines the stored forward metrics, the branch metrics and the backward metrics of the following step into an a-posteriori LLR. The block emits a scaled extrinsic value and a hard decision for that position. Results appear in descending position order. The outer loop of the iterative decoder consumes them as the a-priori values of the other component decoder.

The controller is a three-state machine. In IDLE it accepts loads and starts. In FWD it runs the forward pass, and in BWD it runs the backward pass with output generation. The transitions are GO (IDLE to FWD, on an accepted start), FWD_END (FWD to BWD, after the last forward step) and BWD_END (BWD to IDLE, after position 0).

Top module: `siso_maxlog_dec`

## Requirements
- R1: When `ld_en` is high in IDLE, the three LLRs are written at `ld_addr`. A load while `busy` is high is ignored and leaves the stored block unchanged.
- R2: A `start` in IDLE with `blk_len` in the range [2, MAXLEN] is accepted. `busy` is then high for exactly 2·blk_len−1 cycles, starting on the cycle after the start. A start with any other length, or a start while busy, is ignored.
- R3: After an accepted start, `out_valid` is high for exactly blk_len consecutive cycles, starting blk_len+1 cycles after the start edge. `out_pos` runs from blk_len−1 down to 0, one per cycle.
- R4: Trellis: the state is {s1,s2,s3}, with s1 as bit 2. For input u, the feedback bit is a = u^s2^s3, the parity bit is a^s1^s3, and the next state is {a,s1,s2}.
- R5: The branch metric is (u ? Ls+La : 0) + (parity ? Lp : 0). Both recursions start with metric 0 in state 0 and −2^(MW−4) in all other states, and they use max instead of log-sum.
- R6: The a-posteriori LLR is the maximum of α+γ+β over branches with u=1 minus the maximum over branches with u=0. With x = LLR − Ls − La, the output is x − (x>>>2), saturated to the EW-bit signed range.
- R7: `out_hard` is 1 exactly when the a-posteriori LLR is greater than 0.
- R8: During and after reset the block is idle, with `busy` and `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one step's LLRs into the input buffers |
| ld_addr | input | AW | Trellis step written |
| ld_sys | input | IW | Systematic LLR, signed |
| ld_par | input | IW | Parity LLR, signed |
| ld_apr | input | EW | A-priori LLR, signed |
| start | input | 1 | Launch a decode |
| blk_len | input | LW | Block length for the launched decode |
| busy | output | 1 | Decode in progress |
| out_valid | output | 1 | Output position valid |
| out_pos | output | AW | Position of the current output |
| out_ext | output | EW | Scaled extrinsic LLR, signed |
| out_hard | output | 1 | Hard decision |

## Verification
In every backward cycle the recursion unit replaces the backward metrics. In that same cycle the soft-output stage must still use the old backward metrics, the ones that belong to the next position. The bench therefore checks every position against a reference computed with separately stored metric arrays for each step, so any mix-up between old and new values shows as a wrong extrinsic value. A second collision is a load and a start issued while a run is active. The bench injects both during the forward pass and checks that the outputs of that run are unchanged, and that a repeat run over the same block gives the same results.

// File: rtl/siso_pkg.sv
package siso_pkg;

    localparam int NSTATE = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_BWD  = 2'd2
    } dec_state_e;

    // successor of state {s1,s2,s3} under input u
    function automatic logic [2:0] nxt_state(input logic [2:0] s, input logic u);
        logic fb;
        fb = u ^ s[1] ^ s[0];
        return {fb, s[2], s[1]};
    endfunction

    // parity emitted on the transition from s under input u
    function automatic logic par_bit(input logic [2:0] s, input logic u);
        logic fb;
        fb = u ^ s[1] ^ s[0];
        return fb ^ s[2] ^ s[0];
    endfunction

endpackage

// File: rtl/siso_bmu.sv
module siso_bmu #(
    parameter int IW = 6,
    parameter int EW = IW + 1,
    parameter int MW = 20
) (
    input  logic signed [IW-1:0] sys_llr,
    input  logic signed [IW-1:0] par_llr,
    input  logic signed [EW-1:0] apr_llr,
    output logic signed [MW-1:0] gam [4]
);
    logic signed [MW-1:0] sx, px, ax, info;

    always_comb begin
        sx   = MW'(sys_llr);
        px   = MW'(par_llr);
        ax   = MW'(apr_llr);
        info = sx + ax;
        // index {u, parity}
        gam[0] = '0;
        gam[1] = px;
        gam[2] = info;
        gam[3] = info + px;
    end
endmodule

// File: rtl/siso_acs.sv
module siso_acs
    import siso_pkg::*;
#(
    parameter int MW = 20
) (
    input  logic                 dir_bwd,
    input  logic signed [MW-1:0] met_in  [NSTATE],
    input  logic signed [MW-1:0] gam     [4],
    output logic signed [MW-1:0] met_out [NSTATE]
);
    for (genvar j = 0; j < NSTATE; j++) begin : g_tgt
        localparam logic [2:0] J   = 3'(j);
        // forward: the two predecessors of J
        localparam logic [2:0] F0  = {J[1], J[0], 1'b0};
        localparam logic [2:0] F1  = {J[1], J[0], 1'b1};
        localparam logic       FU0 = J[2] ^ J[0];
        localparam logic       FU1 = J[2] ^ J[0] ^ 1'b1;
        localparam logic [1:0] FG0 = {FU0, par_bit(F0, FU0)};
        localparam logic [1:0] FG1 = {FU1, par_bit(F1, FU1)};
        // backward: the two successors of J
        localparam logic [2:0] B0  = nxt_state(J, 1'b0);
        localparam logic [2:0] B1  = nxt_state(J, 1'b1);
        localparam logic [1:0] BG0 = {1'b0, par_bit(J, 1'b0)};
        localparam logic [1:0] BG1 = {1'b1, par_bit(J, 1'b1)};

        logic signed [MW-1:0] c0, c1;

        always_comb begin
            if (dir_bwd) begin
                c0 = met_in[B0] + gam[BG0];
                c1 = met_in[B1] + gam[BG1];
            end else begin
                c0 = met_in[F0] + gam[FG0];
                c1 = met_in[F1] + gam[FG1];
            end
            met_out[j] = (c0 > c1) ? c0 : c1;
        end
    end
endmodule

// File: rtl/siso_soft_out.sv
module siso_soft_out
    import siso_pkg::*;
#(
    parameter int IW = 6,
    parameter int EW = IW + 1,
    parameter int MW = 20
) (
    input  logic signed [MW-1:0] alpha  [NSTATE],
    input  logic signed [MW-1:0] beta_n [NSTATE],
    input  logic signed [MW-1:0] gam    [4],
    input  logic signed [IW-1:0] sys_llr,
    input  logic signed [EW-1:0] apr_llr,
    output logic signed [EW-1:0] ext_llr,
    output logic                 hard
);
    localparam int SW = MW + 2;
    localparam int XW = SW + 2;
    localparam logic signed [XW-1:0] EMAX = XW'((2 ** (EW - 1)) - 1);
    localparam logic signed [XW-1:0] EMIN = -XW'(2 ** (EW - 1));
    localparam logic signed [SW-1:0] FLOOR = -SW'(2 ** MW);

    logic signed [SW-1:0] m0, m1, t;
    logic signed [XW-1:0] llr, x, y;
    logic [2:0] ns;
    logic [1:0] gi;

    always_comb begin
        m0 = FLOOR;
        m1 = FLOOR;
        for (int s = 0; s < NSTATE; s++) begin
            for (int u = 0; u < 2; u++) begin
                ns = nxt_state(3'(s), 1'(u));
                gi = {1'(u), par_bit(3'(s), 1'(u))};
                t  = SW'(alpha[s]) + SW'(gam[gi]) + SW'(beta_n[ns]);
                if (u == 1) begin
                    if (t > m1) m1 = t;
                end else begin
                    if (t > m0) m0 = t;
                end
            end
        end
        llr = XW'(m1) - XW'(m0);
        x   = llr - XW'(sys_llr) - XW'(apr_llr);
        y   = x - (x >>> 2);
        if (y > EMAX)      ext_llr = EMAX[EW-1:0];
        else if (y < EMIN) ext_llr = EMIN[EW-1:0];
        else               ext_llr = y[EW-1:0];
        hard = (llr > 0);
    end
endmodule

// File: rtl/siso_maxlog_dec.sv
module siso_maxlog_dec
    import siso_pkg::*;
#(
    parameter int IW     = 6,
    parameter int MW     = 20,
    parameter int MAXLEN = 128,
    parameter int EW     = IW + 1,
    parameter int AW     = $clog2(MAXLEN),
    parameter int LW     = $clog2(MAXLEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [AW-1:0]        ld_addr,
    input  logic signed [IW-1:0] ld_sys,
    input  logic signed [IW-1:0] ld_par,
    input  logic signed [EW-1:0] ld_apr,
    input  logic                 start,
    input  logic [LW-1:0]        blk_len,
    output logic                 busy,
    output logic                 out_valid,
    output logic [AW-1:0]        out_pos,
    output logic signed [EW-1:0] out_ext,
    output logic                 out_hard
);
    localparam logic signed [MW-1:0] NEG_INIT = -MW'(2 ** (MW - 4));

    dec_state_e st, st_nxt;

    logic signed [IW-1:0] sys_mem [MAXLEN];
    logic signed [IW-1:0] par_mem [MAXLEN];
    logic signed [EW-1:0] apr_mem [MAXLEN];
    logic signed [MW-1:0] alpha_mem [MAXLEN][NSTATE];

    logic signed [MW-1:0] beta_reg [NSTATE];
    logic signed [MW-1:0] init_met [NSTATE];
    logic signed [MW-1:0] ru_in    [NSTATE];
    logic signed [MW-1:0] ru_out   [NSTATE];
    logic signed [MW-1:0] alpha_rd [NSTATE];
    logic signed [MW-1:0] gam      [4];

    logic [AW-1:0] step;
    logic [LW-1:0] len_q;
    logic          start_ok, fwd_last, bwd_last;
    logic signed [EW-1:0] so_ext;
    logic          so_hard;

    assign start_ok = start && (blk_len >= LW'(2)) && (blk_len <= LW'(MAXLEN));
    assign fwd_last = (step == AW'(len_q - LW'(2)));
    assign bwd_last = (step == '0);

    for (genvar s = 0; s < NSTATE; s++) begin : g_init
        assign init_met[s] = (s == 0) ? '0 : NEG_INIT;
        assign alpha_rd[s] = alpha_mem[step][s];
        assign ru_in[s]    = (st == ST_BWD) ? beta_reg[s] : alpha_rd[s];
    end

    siso_bmu #(.IW(IW), .EW(EW), .MW(MW)) u_bmu (
        .sys_llr (sys_mem[step]),
        .par_llr (par_mem[step]),
        .apr_llr (apr_mem[step]),
        .gam     (gam)
    );

    siso_acs #(.MW(MW)) u_acs (
        .dir_bwd (st == ST_BWD),
        .met_in  (ru_in),
        .gam     (gam),
        .met_out (ru_out)
    );

    siso_soft_out #(.IW(IW), .EW(EW), .MW(MW)) u_so (
        .alpha   (alpha_rd),
        .beta_n  (beta_reg),
        .gam     (gam),
        .sys_llr (sys_mem[step]),
        .apr_llr (apr_mem[step]),
        .ext_llr (so_ext),
        .hard    (so_hard)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // transitions GO, FWD_END, BWD_END
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (start_ok) st_nxt = ST_FWD;
            ST_FWD:  if (fwd_last) st_nxt = ST_BWD;
            ST_BWD:  if (bwd_last) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // input buffers and forward metric memory
    always_ff @(posedge clk) begin
        if (st == ST_IDLE && ld_en) begin
            sys_mem[ld_addr] <= ld_sys;
            par_mem[ld_addr] <= ld_par;
            apr_mem[ld_addr] <= ld_apr;
        end
        if (st == ST_IDLE && start_ok) begin
            for (int s = 0; s < NSTATE; s++) alpha_mem[0][s] <= init_met[s];
        end else if (st == ST_FWD) begin
            for (int s = 0; s < NSTATE; s++) alpha_mem[step + AW'(1)][s] <= ru_out[s];
        end
    end

    // step counter and backward metrics
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step  <= '0;
            len_q <= '0;
            for (int s = 0; s < NSTATE; s++) beta_reg[s] <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start_ok) begin
                        len_q <= blk_len;
                        step  <= '0;
                    end
                end
                ST_FWD: begin
                    if (fwd_last) begin
                        step <= AW'(len_q - LW'(1));
                        for (int s = 0; s < NSTATE; s++) beta_reg[s] <= init_met[s];
                    end else begin
                        step <= step + AW'(1);
                    end
                end
                ST_BWD: begin
                    for (int s = 0; s < NSTATE; s++) beta_reg[s] <= ru_out[s];
                    step <= step - AW'(1);
                end
                default: step <= '0;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pos   <= '0;
            out_ext   <= '0;
            out_hard  <= 1'b0;
        end else begin
            out_valid <= (st == ST_BWD);
            if (st == ST_BWD) begin
                out_pos  <= step;
                out_ext  <= so_ext;
                out_hard <= so_hard;
            end
        end
    end

    assign busy = (st != ST_IDLE);

endmodule

// File: rtl/siso_maxlog_dec_chk.sv
module siso_maxlog_dec_chk #(
    parameter int AW = 7,
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [LW-1:0] blk_len,
    input logic          busy,
    input logic          out_valid,
    input logic [AW-1:0] out_pos
);
    logic [LW-1:0] len_d, run_len;
    logic [LW:0]   busy_cnt;
    logic          busy_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_d    <= '0;
            run_len  <= '0;
            busy_cnt <= '0;
            busy_d   <= 1'b0;
        end else begin
            len_d  <= blk_len;
            busy_d <= busy;
            if (busy && !busy_d) run_len <= len_d;
            busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
        end
    end

    assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == {run_len, 1'b0} - 1'b1));

    assert_valid_within_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));

    assert_first_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_pos == AW'(run_len - 1'b1)));

    assert_pos_descends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_pos == $past(out_pos) - 1'b1));

    assert_last_pos_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> ($past(out_pos) == '0));
endmodule

bind siso_maxlog_dec siso_maxlog_dec_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .blk_len   (blk_len),
    .busy      (busy),
    .out_valid (out_valid),
    .out_pos   (out_pos)
);

// File: tb/siso_maxlog_dec_bench.sv
module siso_maxlog_dec_bench;
    localparam int IW = 6, EW = 7, MAXLEN = 128, AW = 7, LW = 8;
    localparam int NEG = -65536;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, ld_en = 1'b0, start = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic signed [IW-1:0] ld_sys = '0, ld_par = '0;
    logic signed [EW-1:0] ld_apr = '0;
    logic [LW-1:0] blk_len = '0;
    logic busy, out_valid, out_hard;
    logic [AW-1:0] out_pos;
    logic signed [EW-1:0] out_ext;

    siso_maxlog_dec u_siso_maxlog_dec (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_sys(ld_sys), .ld_par(ld_par), .ld_apr(ld_apr),
        .start(start), .blk_len(blk_len), .busy(busy),
        .out_valid(out_valid), .out_pos(out_pos), .out_ext(out_ext),
        .out_hard(out_hard)
    );

    int n_chk = 0, n_fail = 0;
    int r_sys [MAXLEN], r_par [MAXLEN], r_apr [MAXLEN];
    int e_ext [MAXLEN], e_hard [MAXLEN];
    int al [MAXLEN+1][8], be [MAXLEN+1][8];

    function automatic int nx(int s, int u);
        int a = (u ^ (s >> 1) ^ s) & 1;
        return (a << 2) | ((s >> 1) & 3);
    endfunction

    function automatic int pb(int s, int u);
        int a = (u ^ (s >> 1) ^ s) & 1;
        return (a ^ (s >> 2) ^ s) & 1;
    endfunction

    function automatic int gm(int k, int s, int u);
        return (u != 0 ? r_sys[k] + r_apr[k] : 0) + (pb(s, u) != 0 ? r_par[k] : 0);
    endfunction

    task automatic compute(input int L);
        for (int s = 0; s < 8; s++) begin
            al[0][s] = (s == 0) ? 0 : NEG;
            be[L][s] = (s == 0) ? 0 : NEG;
        end
        for (int k = 0; k < L - 1; k++) begin
            for (int n = 0; n < 8; n++) al[k+1][n] = -1000000000;
            for (int s = 0; s < 8; s++)
                for (int u = 0; u < 2; u++)
                    if (al[k][s] + gm(k, s, u) > al[k+1][nx(s, u)])
                        al[k+1][nx(s, u)] = al[k][s] + gm(k, s, u);
        end
        for (int k = L - 1; k >= 0; k--) begin
            int mx [2];
            for (int s = 0; s < 8; s++) begin
                int b0 = be[k+1][nx(s, 0)] + gm(k, s, 0);
                int b1 = be[k+1][nx(s, 1)] + gm(k, s, 1);
                be[k][s] = (b0 > b1) ? b0 : b1;
            end
            mx[0] = -1000000000; mx[1] = -1000000000;
            for (int s = 0; s < 8; s++)
                for (int u = 0; u < 2; u++)
                    if (al[k][s] + gm(k, s, u) + be[k+1][nx(s, u)] > mx[u])
                        mx[u] = al[k][s] + gm(k, s, u) + be[k+1][nx(s, u)];
            begin
                int llr = mx[1] - mx[0];
                int x = llr - r_sys[k] - r_apr[k];
                int y = x - (x >>> 2);
                if (y > 63) y = 63;
                if (y < -64) y = -64;
                e_ext[k] = y;
                e_hard[k] = (llr > 0) ? 1 : 0;
            end
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0 random, 1 extreme magnitudes, 2 all strongly positive
    task automatic load_block(input int L, input int mode);
        for (int k = 0; k < L; k++) begin
            @(negedge clk);
            case (mode)
                1: begin
                    r_sys[k] = ($urandom % 2) ? 31 : -32;
                    r_par[k] = ($urandom % 2) ? 31 : -32;
                    r_apr[k] = ($urandom % 2) ? 63 : -64;
                end
                2: begin
                    r_sys[k] = 20 + int'($urandom % 12);
                    r_par[k] = int'($urandom % 64) - 32;
                    r_apr[k] = 30;
                end
                default: begin
                    r_sys[k] = int'($urandom % 64) - 32;
                    r_par[k] = int'($urandom % 64) - 32;
                    r_apr[k] = int'($urandom % 128) - 64;
                end
            endcase
            ld_en = 1'b1; ld_addr = AW'(k);
            ld_sys = IW'(r_sys[k]); ld_par = IW'(r_par[k]); ld_apr = EW'(r_apr[k]);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // runs one decode; disturb injects a load and a start while busy (R1, R2)
    task automatic run(input int L, input bit disturb);
        compute(L);
        start = 1'b1; blk_len = LW'(L);
        for (int cyc = 1; cyc <= 2 * L + 1; cyc++) begin
            int j = cyc - 1;
            bit ev = (j >= L) && (j <= 2 * L - 1);
            @(negedge clk);
            check("R2 busy", int'(busy), (j <= 2 * L - 2) ? 1 : 0);
            check("R3 out_valid", int'(out_valid), ev ? 1 : 0);
            if (ev && out_valid) begin
                int p = 2 * L - 1 - j;
                check("R3 out_pos", int'(out_pos), p);
                check("R6 out_ext", int'(out_ext), e_ext[p]);
                check("R7 out_hard", int'(out_hard), e_hard[p]);
            end
            start = 1'b0;
            ld_en = 1'b0;
            if (disturb && cyc == 2) begin
                start = 1'b1; blk_len = LW'(5);
                ld_en = 1'b1; ld_addr = '0;
                ld_sys = IW'(-r_sys[0] - 1); ld_par = IW'(-r_par[0] - 1); ld_apr = EW'(-r_apr[0] - 1);
            end
        end
        ld_en = 1'b0; start = 1'b0;
    endtask

    task automatic bad_start(input int L);
        @(negedge clk);
        start = 1'b1; blk_len = LW'(L);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3; c++) begin
            check("R2 bad length ignored, busy", int'(busy), 0);
            check("R2 bad length ignored, out_valid", int'(out_valid), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 busy in reset", int'(busy), 0);
        check("R8 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 busy after reset", int'(busy), 0);
        check("R8 out_valid after reset", int'(out_valid), 0);

        // R4 R5 R6 R7: random block
        load_block(16, 0);
        run(16, 1'b0);
        // R2 R3: shortest block
        load_block(2, 0);
        run(2, 1'b0);
        // R6: saturation with extreme inputs at the largest length
        load_block(MAXLEN, 1);
        run(MAXLEN, 1'b0);
        // R7: strongly positive information
        load_block(24, 2);
        run(24, 1'b0);
        // R1 R2: load and start while busy are ignored; repeat shows buffer intact
        load_block(12, 0);
        run(12, 1'b1);
        @(negedge clk);
        run(12, 1'b0);
        // R2: out-of-range lengths
        bad_start(1);
        bad_start(0);
        bad_start(MAXLEN + 1);
        // R5: odd length, random again
        load_block(37, 0);
        run(37, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule